// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a record of the most recent reset or wake-up in a small microcontroller core. It holds four flags: a power-on flag and a brown-out flag, which are active-low and which software re-arms, plus a time-out flag and a power-down flag. It also tracks whether the core is in sleep. For every reset or wake-up it computes the address at which execution restarts.

Events reach the block as single-cycle strobes. When several strobes arrive in the same cycle, a fixed priority picks one, and only that event is applied. The flags and the restart address are registered, so they change at the clock edge that samples the strobe.

A software write port loads the two status bits. The status byte reads back with the power-on flag in bit 1, the brown-out flag in bit 0, and zeros above.

Top module: `rstcause_top`

## Requirements
- R1: While `rst` is high, and from the first edge after it, the outputs read power-on flag 0, brown-out flag 0, time-out 1, power-down 1, `restart_pc` 0 and `restart_vld` 0. The core is awake.
- R2: A power-on strobe clears the power-on flag, sets time-out and power-down, leaves the brown-out flag unchanged, wakes the core and restarts at address 0.
- R3: A brown-out strobe with `bor_en` high clears the brown-out flag, leaves the power-on flag unchanged, sets time-out and power-down, wakes the core and restarts at 0. With `bor_en` low the strobe has no effect at all.
- R4: A master-clear strobe while awake leaves time-out and power-down unchanged. While asleep it sets time-out and clears power-down. In both cases it wakes the core and restarts at 0.
- R5: A watchdog overflow while awake clears time-out, sets power-down and restarts at 0. While asleep it clears both flags and restarts at `pc_cur`+1, which wraps to 0 at the top of the address range. Either way the core ends awake.
- R6: An interrupt wake while asleep sets time-out, clears power-down and wakes the core. It restarts at `pc_cur`+1 when `gie` is 0, and at 0x004 when `gie` is 1. While awake the strobe has no effect.
- R7: A sleep strobe while awake sets time-out, clears power-down and puts the core to sleep. A clear-watchdog strobe while awake sets both time-out and power-down. Both strobes have no effect while asleep.
- R8: Priority from highest to lowest: power-on, brown-out, master-clear, watchdog, interrupt wake, sleep, clear-watchdog. Only the winning event changes any state.
- R9: When `sw_wr` is high, the power-on flag takes `sw_wdata[1]` and the brown-out flag takes `sw_wdata[0]`, unless a power-on or enabled brown-out event is applied in the same cycle. `status_rd` is {6'b0, power-on flag, brown-out flag}.
- R10: `restart_vld` is high for exactly the cycle after an applied reset or wake event (R2 to R6) and low otherwise. `restart_pc` holds its value whenever `restart_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_por | input | 1 | Power-on event strobe |
| ev_bor | input | 1 | Brown-out event strobe |
| ev_mclr | input | 1 | External master-clear strobe |
| ev_wdt_ovf | input | 1 | Watchdog overflow strobe |
| ev_sleep | input | 1 | Sleep entry strobe |
| ev_clrwdt | input | 1 | Clear-watchdog instruction strobe |
| ev_irq_wake | input | 1 | Interrupt wake strobe |
| bor_en | input | 1 | Brown-out detection enable strap |
| gie | input | 1 | Global interrupt enable |
| pc_cur | input | PC_W | Current program counter |
| sw_wr | input | 1 | Software write of status bits |
| sw_wdata | input | 2 | Write data: bit 1 power-on, bit 0 brown-out |
| flag_por | output | 1 | Power-on flag (0 after power-on) |
| flag_bor | output | 1 | Brown-out flag (0 after brown-out) |
| flag_to | output | 1 | Time-out flag |
| flag_pd | output | 1 | Power-down flag |
| status_rd | output | 8 | Status byte readback |
| restart_pc | output | PC_W | Restart address |
| restart_vld | output | 1 | Restart address valid pulse |

## Verification
The sleep state is internal and has no port of its own. A wrong sleep state therefore shows up at the next watchdog, master-clear or interrupt strobe, as a wrong time-out/power-down pair or a wrong restart address. A wrong priority decision, or a flag update that was lost, becomes visible on the outputs one edge after the strobe. A long sweep is used so that every event meets both sleep states and most overlapping combinations of strobes.

// File: rtl/rstcause_pkg.sv
package rstcause_pkg;

    typedef enum logic [3:0] {
        RC_NONE,
        RC_POR,
        RC_BOR,
        RC_MCLR_RUN,
        RC_MCLR_SLP,
        RC_WDT_RST,
        RC_WDT_WAKE,
        RC_IRQ_WAKE,
        RC_SLEEP,
        RC_CLRWDT
    } rc_cause_e;

    typedef struct packed {
        logic por_n;
        logic bor_n;
        logic to;
        logic pd;
    } rc_flags_t;

    typedef struct packed {
        logic por;
        logic bor;
        logic mclr;
        logic wdt;
        logic irq;
        logic sleep;
        logic clrwdt;
    } rc_events_t;

    localparam rc_flags_t RC_FLAGS_INIT = '{por_n: 1'b0, bor_n: 1'b0, to: 1'b1, pd: 1'b1};

    // Next flag value for a given winning event, before any software write.
    function automatic rc_flags_t rc_next_flags(rc_cause_e c, rc_flags_t f);
        rc_flags_t n = f;
        unique case (c)
            RC_POR:      begin n.por_n = 1'b0; n.to = 1'b1; n.pd = 1'b1; end
            RC_BOR:      begin n.bor_n = 1'b0; n.to = 1'b1; n.pd = 1'b1; end
            RC_MCLR_RUN: ;
            RC_MCLR_SLP: begin n.to = 1'b1; n.pd = 1'b0; end
            RC_WDT_RST:  begin n.to = 1'b0; n.pd = 1'b1; end
            RC_WDT_WAKE: begin n.to = 1'b0; n.pd = 1'b0; end
            RC_IRQ_WAKE: begin n.to = 1'b1; n.pd = 1'b0; end
            RC_SLEEP:    begin n.to = 1'b1; n.pd = 1'b0; end
            RC_CLRWDT:   begin n.to = 1'b1; n.pd = 1'b1; end
            default:     ;
        endcase
        return n;
    endfunction

    // Events that redirect execution and leave the core awake.
    function automatic logic rc_is_redirect(rc_cause_e c);
        return (c == RC_POR) || (c == RC_BOR) || (c == RC_MCLR_RUN) ||
               (c == RC_MCLR_SLP) || (c == RC_WDT_RST) || (c == RC_WDT_WAKE) ||
               (c == RC_IRQ_WAKE);
    endfunction

    // Events that own the status bits and block a software write.
    function automatic logic rc_owns_status(rc_cause_e c);
        return (c == RC_POR) || (c == RC_BOR);
    endfunction

endpackage

// File: rtl/rstcause_arbiter.sv
module rstcause_arbiter
    import rstcause_pkg::*;
(
    input  rc_events_t ev,
    input  logic       bor_en,
    input  logic       asleep,
    output rc_cause_e  cause
);
    always_comb begin
        if (ev.por)                 cause = RC_POR;
        else if (ev.bor && bor_en)  cause = RC_BOR;
        else if (ev.mclr)           cause = asleep ? RC_MCLR_SLP : RC_MCLR_RUN;
        else if (ev.wdt)            cause = asleep ? RC_WDT_WAKE : RC_WDT_RST;
        else if (ev.irq && asleep)  cause = RC_IRQ_WAKE;
        else if (ev.sleep && !asleep)  cause = RC_SLEEP;
        else if (ev.clrwdt && !asleep) cause = RC_CLRWDT;
        else                        cause = RC_NONE;
    end
endmodule

// File: rtl/rstcause_flags.sv
module rstcause_flags
    import rstcause_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  rc_cause_e  cause,
    input  logic       sw_wr,
    input  logic [1:0] sw_wdata,
    output rc_flags_t  flags,
    output logic       asleep
);
    rc_flags_t flags_nxt;

    always_comb begin
        flags_nxt = rc_next_flags(cause, flags);
        if (sw_wr && !rc_owns_status(cause)) begin
            flags_nxt.por_n = sw_wdata[1];
            flags_nxt.bor_n = sw_wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags  <= RC_FLAGS_INIT;
            asleep <= 1'b0;
        end else begin
            flags <= flags_nxt;
            if (cause == RC_SLEEP)
                asleep <= 1'b1;
            else if (rc_is_redirect(cause))
                asleep <= 1'b0;
        end
    end
endmodule

// File: rtl/rstcause_restart.sv
module rstcause_restart
    import rstcause_pkg::*;
#(
    parameter int PC_W    = 13,
    parameter int IRQ_VEC = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  rc_cause_e       cause,
    input  logic            gie,
    input  logic [PC_W-1:0] pc_cur,
    output logic [PC_W-1:0] restart_pc,
    output logic            restart_vld
);
    localparam logic [PC_W-1:0] VEC_ADDR = PC_W'(IRQ_VEC);
    localparam logic [PC_W-1:0] ZERO_ADDR = '0;

    logic [PC_W-1:0] pc_inc;
    logic [PC_W-1:0] pc_sel;

    assign pc_inc = pc_cur + PC_W'(1);

    always_comb begin
        unique case (cause)
            RC_WDT_WAKE: pc_sel = pc_inc;
            RC_IRQ_WAKE: pc_sel = gie ? VEC_ADDR : pc_inc;
            default:     pc_sel = ZERO_ADDR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            restart_pc  <= ZERO_ADDR;
            restart_vld <= 1'b0;
        end else begin
            restart_vld <= rc_is_redirect(cause);
            if (rc_is_redirect(cause))
                restart_pc <= pc_sel;
        end
    end
endmodule

// File: rtl/rstcause_top.sv
module rstcause_top
    import rstcause_pkg::*;
#(
    parameter int PC_W    = 13,
    parameter int IRQ_VEC = 4,
    parameter int STAT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_por,
    input  logic              ev_bor,
    input  logic              ev_mclr,
    input  logic              ev_wdt_ovf,
    input  logic              ev_sleep,
    input  logic              ev_clrwdt,
    input  logic              ev_irq_wake,
    input  logic              bor_en,
    input  logic              gie,
    input  logic [PC_W-1:0]   pc_cur,
    input  logic              sw_wr,
    input  logic [1:0]        sw_wdata,
    output logic              flag_por,
    output logic              flag_bor,
    output logic              flag_to,
    output logic              flag_pd,
    output logic [STAT_W-1:0] status_rd,
    output logic [PC_W-1:0]   restart_pc,
    output logic              restart_vld
);
    localparam int PAD_W = STAT_W - 2;

    rc_events_t ev;
    rc_cause_e  cause;
    rc_flags_t  flags;
    logic       asleep;

    assign ev = '{por: ev_por, bor: ev_bor, mclr: ev_mclr, wdt: ev_wdt_ovf,
                  irq: ev_irq_wake, sleep: ev_sleep, clrwdt: ev_clrwdt};

    rstcause_arbiter u_arb (
        .ev     (ev),
        .bor_en (bor_en),
        .asleep (asleep),
        .cause  (cause)
    );

    rstcause_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .cause    (cause),
        .sw_wr    (sw_wr),
        .sw_wdata (sw_wdata),
        .flags    (flags),
        .asleep   (asleep)
    );

    rstcause_restart #(.PC_W(PC_W), .IRQ_VEC(IRQ_VEC)) u_restart (
        .clk         (clk),
        .rst         (rst),
        .cause       (cause),
        .gie         (gie),
        .pc_cur      (pc_cur),
        .restart_pc  (restart_pc),
        .restart_vld (restart_vld)
    );

    assign flag_por  = flags.por_n;
    assign flag_bor  = flags.bor_n;
    assign flag_to   = flags.to;
    assign flag_pd   = flags.pd;
    assign status_rd = {{PAD_W{1'b0}}, flags.por_n, flags.bor_n};
endmodule

// File: rtl/rstcause_chk.sv
module rstcause_chk #(
    parameter int PC_W = 13
) (
    input logic            clk,
    input logic            rst,
    input logic            ev_por,
    input logic            ev_bor,
    input logic            ev_mclr,
    input logic            ev_wdt_ovf,
    input logic            ev_irq_wake,
    input logic            bor_en,
    input logic            sw_wr,
    input logic            flag_por,
    input logic            flag_bor,
    input logic            flag_to,
    input logic            flag_pd,
    input logic [PC_W-1:0] restart_pc,
    input logic            restart_vld
);
    logic bor_live;
    assign bor_live = ev_bor && bor_en;

    p_por_entry_r2: assert property (@(posedge clk) disable iff (rst)
        ev_por |=> (!flag_por && flag_to && flag_pd && restart_vld && restart_pc == '0));

    p_por_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!ev_por && !sw_wr) |=> $stable(flag_por));

    p_bor_entry_r3: assert property (@(posedge clk) disable iff (rst)
        (bor_live && !ev_por) |=> (!flag_bor && flag_to && flag_pd && restart_vld && restart_pc == '0));

    p_bor_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!bor_live && !sw_wr) |=> $stable(flag_bor));

    p_mclr_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (ev_mclr && !ev_por && !bor_live) |=> (restart_vld && restart_pc == '0));

    // R8: a watchdog strobe wins over interrupt, sleep and clear-watchdog.
    p_wdt_clears_to_r5: assert property (@(posedge clk) disable iff (rst)
        (ev_wdt_ovf && !ev_por && !bor_live && !ev_mclr) |=> !flag_to);

    p_quiet_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(ev_por || ev_bor || ev_mclr || ev_wdt_ovf || ev_irq_wake) |=> (!restart_vld && $stable(restart_pc)));
endmodule

bind rstcause_top rstcause_chk #(.PC_W(PC_W)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .ev_por      (ev_por),
    .ev_bor      (ev_bor),
    .ev_mclr     (ev_mclr),
    .ev_wdt_ovf  (ev_wdt_ovf),
    .ev_irq_wake (ev_irq_wake),
    .bor_en      (bor_en),
    .sw_wr       (sw_wr),
    .flag_por    (flag_por),
    .flag_bor    (flag_bor),
    .flag_to     (flag_to),
    .flag_pd     (flag_pd),
    .restart_pc  (restart_pc),
    .restart_vld (restart_vld)
);

// File: tb/test_rstcause_top.sv
module test_rstcause_top;
    localparam int PC_W = 13;
    localparam logic [PC_W-1:0] VEC = 13'h004;
    localparam int NVEC = 4000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ev_por = 0, ev_bor = 0, ev_mclr = 0, ev_wdt_ovf = 0;
    logic ev_sleep = 0, ev_clrwdt = 0, ev_irq_wake = 0;
    logic bor_en = 0, gie = 0, sw_wr = 0;
    logic [PC_W-1:0] pc_cur = '0;
    logic [1:0] sw_wdata = '0;
    logic flag_por, flag_bor, flag_to, flag_pd, restart_vld;
    logic [7:0] status_rd;
    logic [PC_W-1:0] restart_pc;

    always #4 clk = ~clk;

    rstcause_top i_rstcause_top (
        .clk(clk), .rst(rst), .ev_por(ev_por), .ev_bor(ev_bor), .ev_mclr(ev_mclr),
        .ev_wdt_ovf(ev_wdt_ovf), .ev_sleep(ev_sleep), .ev_clrwdt(ev_clrwdt),
        .ev_irq_wake(ev_irq_wake), .bor_en(bor_en), .gie(gie), .pc_cur(pc_cur),
        .sw_wr(sw_wr), .sw_wdata(sw_wdata), .flag_por(flag_por), .flag_bor(flag_bor),
        .flag_to(flag_to), .flag_pd(flag_pd), .status_rd(status_rd),
        .restart_pc(restart_pc), .restart_vld(restart_vld)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    logic m_por, m_bor, m_to, m_pd, m_slp, m_vld;
    logic [PC_W-1:0] m_pc;
    string tag;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(tag, "flag_por", 32'(flag_por), 32'(m_por));
        chk(tag, "flag_bor", 32'(flag_bor), 32'(m_bor));
        chk(tag, "flag_to", 32'(flag_to), 32'(m_to));
        chk(tag, "flag_pd", 32'(flag_pd), 32'(m_pd));
        chk("R10", "restart_vld", 32'(restart_vld), 32'(m_vld));
        chk(tag, "restart_pc", 32'(restart_pc), 32'(m_pc));
        chk("R9", "status_rd", 32'(status_rd), {30'd0, m_por, m_bor});
    endtask

    // Expected next state, from the requirement list.
    task automatic model_step();
        int act_cnt;
        bit owns;
        act_cnt = int'(ev_por) + int'(ev_bor) + int'(ev_mclr) + int'(ev_wdt_ovf) +
                  int'(ev_sleep) + int'(ev_clrwdt) + int'(ev_irq_wake);
        owns = 0;
        m_vld = 0;
        if (ev_por) begin
            m_por = 0; m_to = 1; m_pd = 1; m_slp = 0; m_pc = '0; m_vld = 1; owns = 1; tag = "R2";
        end else if (ev_bor && bor_en) begin
            m_bor = 0; m_to = 1; m_pd = 1; m_slp = 0; m_pc = '0; m_vld = 1; owns = 1; tag = "R3";
        end else if (ev_mclr) begin
            if (m_slp) begin m_to = 1; m_pd = 0; end
            m_slp = 0; m_pc = '0; m_vld = 1; tag = "R4";
        end else if (ev_wdt_ovf) begin
            if (m_slp) begin m_to = 0; m_pd = 0; m_pc = pc_cur + 1'b1; end
            else begin m_to = 0; m_pd = 1; m_pc = '0; end
            m_slp = 0; m_vld = 1; tag = "R5";
        end else if (ev_irq_wake && m_slp) begin
            m_to = 1; m_pd = 0; m_pc = gie ? VEC : pc_cur + 1'b1; m_slp = 0; m_vld = 1; tag = "R6";
        end else if (ev_sleep && !m_slp) begin
            m_to = 1; m_pd = 0; m_slp = 1; tag = "R7";
        end else if (ev_clrwdt && !m_slp) begin
            m_to = 1; m_pd = 1; tag = "R7";
        end else begin
            tag = (ev_bor || ev_irq_wake || ev_sleep || ev_clrwdt) ? "R6" : "R9";
            if (ev_bor) tag = "R3";
        end
        if (act_cnt > 1) tag = "R8";
        if (sw_wr && !owns) begin
            m_por = sw_wdata[1]; m_bor = sw_wdata[0];
        end
    endtask

    task automatic apply();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        {ev_por, ev_bor, ev_mclr, ev_wdt_ovf, ev_sleep, ev_clrwdt, ev_irq_wake, sw_wr} = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        tag = "R1";
        m_por = 0; m_bor = 0; m_to = 1; m_pd = 1; m_slp = 0; m_vld = 0; m_pc = '0;
        compare_all();
        rst = 0;
        @(negedge clk);
        compare_all();

        // R9: software arms both status bits
        sw_wr = 1; sw_wdata = 2'b11; apply();
        // R7: sleep, then R5: watchdog wake with PC at the top wraps to zero
        ev_sleep = 1; apply();
        ev_wdt_ovf = 1; pc_cur = '1; apply();
        // R6: interrupt wake with gie high goes to the vector
        ev_sleep = 1; apply();
        ev_irq_wake = 1; gie = 1; pc_cur = 13'h123; apply();
        // R3: disabled brown-out has no effect
        bor_en = 0; ev_bor = 1; apply();

        for (int i = 0; i < NVEC; i++) begin
            logic [31:0] h;
            h = 32'(i) * 32'h9E3779B1;
            h = h ^ (h >> 15);
            {ev_por, ev_bor, ev_mclr, ev_wdt_ovf, ev_irq_wake, ev_sleep, ev_clrwdt} =
                h[6:0] & h[13:7] & h[20:14] & {2'b11, h[30], 4'b1111};
            bor_en   = h[21] | h[22];
            gie      = h[23];
            sw_wr    = h[24] & h[25] & h[26];
            sw_wdata = h[28:27];
            pc_cur   = (h[29:27] == 3'd0) ? '1 : (h[12:0] ^ 13'(i));
            apply();
        end

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired actual hung expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule